// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block generates the word address for a synchronous burst read out of a memory array whose words are 16 bits wide and whose word address is 19 bits wide. A clock edge with the active-low load strobe low captures a start address. After that, each clock edge with the active-low advance strobe low moves the burst on by one word. The burst covers 32 consecutive words from the start word. It does not wrap at an aligned boundary: one advance past the last word returns it to the start word itself.

The block drives the current word address to the array's read port every cycle and registers the returned word onto its data output. It also registers an active-low end flag that is low while the last word of the window is on the output. Output enable and chip enable are combined without the clock, so the data bus reads zero at once when either enable is high.

Top module: `bsq_top`

## Requirements
- R1: A rising edge with `load_n` low sets `rd_addr` to `addr` from the next cycle. One cycle after that, `dq` shows the array word at that address.
- R2: While `load_n` is high, changes on `addr` have no effect on `rd_addr` or `dq`.
- R3: A rising edge with `advance_n` low and `load_n` high moves `rd_addr` to the next word of the burst. `dq` follows one cycle later.
- R4: A rising edge with both strobes high leaves `rd_addr` unchanged, and `dq` stays unchanged one cycle later.
- R5: `end_n` is 0 in exactly the cycles where `dq` presents the word at offset 31 from the start address, and 1 in all other cycles.
- R6: One advance after offset 31 returns `rd_addr` to the start address, so the burst repeats with a period of 32 advances.
- R7: When `load_n` and `advance_n` are both low on the same edge, the load wins and the offset restarts at 0.
- R8: The burst address is the start address plus the offset, taken modulo 2^19, so a burst that starts near 0x7FFFF wraps through address 0.
- R9: A synchronous active-high `rst` sets the start address and offset to 0, the registered data to 0 and `end_n` to 1.
- R10: `dq` equals the registered word only while `ce_n` and `oe_n` are both 0. Otherwise it is 0, and this gating takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low, not clocked |
| oe_n | input | 1 | Output enable, active low, not clocked |
| load_n | input | 1 | Load strobe, active low, captures `addr` |
| advance_n | input | 1 | Advance strobe, active low |
| addr | input | 19 | Burst start word address |
| rd_addr | output | 19 | Word address to the array read port |
| rd_data | input | 16 | Word returned by the array for `rd_addr` |
| dq | output | 16 | Gated registered output word |
| end_n | output | 1 | Low while the last word of the burst is output |

## Verification
The bench builds the block with its default parameters: a 19-bit address, 16-bit words and a 32-word window. These defaults make the modulo-2^19 crossing at 0x7FFFF and the full 32-advance wrap reachable in a short run. A behavioural model based on integers follows the start address and offset. A mix of directed sequences and pseudo-random strobes then exercises pauses in the middle of a burst, reloads during a burst and simultaneous strobes.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int unsigned BSQ_ADDR_W = 19;
  localparam int unsigned BSQ_DATA_W = 16;
  localparam int unsigned BSQ_BURST  = 32;

  typedef enum logic [1:0] {
    BSQ_HOLD    = 2'd0,
    BSQ_ADVANCE = 2'd1,
    BSQ_LOAD    = 2'd2
  } bsq_cmd_e;

  function automatic bsq_cmd_e bsq_decode(input logic load_n, input logic advance_n);
    if (!load_n)         return BSQ_LOAD;
    else if (!advance_n) return BSQ_ADVANCE;
    else                 return BSQ_HOLD;
  endfunction
endpackage

// File: rtl/bsq_offset_ctr.sv
module bsq_offset_ctr #(
  parameter int unsigned BURST = 32,
  localparam int unsigned OFF_W = $clog2(BURST)
) (
  input  logic             clk,
  input  logic             rst,
  input  bsq_pkg::bsq_cmd_e cmd,
  output logic [OFF_W-1:0] offset,
  output logic             at_last
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BURST - 1);

  logic [OFF_W-1:0] off_q;

  assign at_last = (off_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
    end else begin
      unique case (cmd)
        bsq_pkg::BSQ_LOAD:    off_q <= '0;
        bsq_pkg::BSQ_ADVANCE: off_q <= at_last ? '0 : off_q + 1'b1;
        default:              off_q <= off_q;
      endcase
    end
  end

  assign offset = off_q;
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  bsq_pkg::bsq_cmd_e cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] start_q;

  always_ff @(posedge clk) begin
    if (rst)                          start_q <= '0;
    else if (cmd == bsq_pkg::BSQ_LOAD) start_q <= addr;
  end

  // Sum truncates to ADDR_W bits: modulo 2^ADDR_W.
  assign cur_addr = start_q + ADDR_W'(offset);
endmodule

// File: rtl/bsq_out_stage.sv
module bsq_out_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              at_last,
  output logic [DATA_W-1:0] dq,
  output logic              end_n
);
  logic [DATA_W-1:0] word_q;
  logic              end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      end_q  <= 1'b1;
    end else begin
      word_q <= rd_data;
      end_q  <= ~at_last;
    end
  end

  logic drive_en;
  assign drive_en = ~ce_n & ~oe_n;
  assign dq       = drive_en ? word_q : '0;
  assign end_n    = end_q;
endmodule

// File: rtl/bsq_top.sv
module bsq_top #(
  parameter int unsigned ADDR_W = bsq_pkg::BSQ_ADDR_W,
  parameter int unsigned DATA_W = bsq_pkg::BSQ_DATA_W,
  parameter int unsigned BURST  = bsq_pkg::BSQ_BURST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              load_n,
  input  logic              advance_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq,
  output logic              end_n
);
  localparam int unsigned OFF_W = $clog2(BURST);

  bsq_pkg::bsq_cmd_e cmd;
  logic [OFF_W-1:0]  offset;
  logic              at_last;

  assign cmd = bsq_pkg::bsq_decode(load_n, advance_n);

  bsq_offset_ctr #(.BURST(BURST)) u_off (
    .clk(clk), .rst(rst), .cmd(cmd), .offset(offset), .at_last(at_last)
  );

  bsq_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .offset(offset),
    .cur_addr(rd_addr)
  );

  bsq_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data),
    .at_last(at_last), .dq(dq), .end_n(end_n)
  );
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              load_n,
  input logic              advance_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] dq,
  input logic              end_n,
  input logic [OFF_W-1:0]  offset
);
  localparam logic [OFF_W-1:0] LAST = '1;

  p_load_addr_r1: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> rd_addr == $past(addr));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (load_n && !advance_n && offset != LAST) |=> rd_addr == $past(rd_addr) + 1'b1);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n && advance_n) |=> $stable(rd_addr));

  p_last_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (offset == LAST) |=> !end_n);

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (load_n && !advance_n && offset == LAST) |=> offset == '0);

  p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !advance_n) |=> offset == '0);

  p_reset_flag_r9: assert property (@(posedge clk)
    rst |=> end_n);

  always @(posedge clk) begin
    if (!rst && (ce_n || oe_n))
      p_gate_r10: assert (dq == '0);
  end
endmodule

bind bsq_top bsq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .load_n(load_n),
  .advance_n(advance_n), .addr(addr), .rd_addr(rd_addr), .dq(dq),
  .end_n(end_n), .offset(offset)
);

// File: tb/sim_bsq_top.sv
`timescale 1ns/1ps
module sim_bsq_top;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int M  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0, oe_n = 1'b0, load_n = 1'b1, advance_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data, dq;
  logic end_n;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    logic [31:0] x;
    x = {13'd0, a} * 32'd40503;
    return x[DW-1:0] ^ {a[AW-1:AW-3], 13'd0} ^ 16'h5A3C;
  endfunction

  assign rd_data = memf(rd_addr);

  bsq_top u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .load_n(load_n),
    .advance_n(advance_n), .addr(addr), .rd_addr(rd_addr), .rd_data(rd_data),
    .dq(dq), .end_n(end_n)
  );

  int compared = 0, mismatched = 0;
  int m_start = 0, m_off = 0;
  logic [DW-1:0] m_word = '0;
  logic m_end = 1'b1;
  string tag = "R9";

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_off = 0; m_word = '0; m_end = 1'b1;
    end else begin
      m_word = memf(AW'((m_start + m_off) % M));
      m_end  = (m_off != 31);
      if (!load_n) begin
        m_start = int'(addr); m_off = 0;
      end else if (!advance_n) begin
        m_off = (m_off + 1) % 32;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    begin
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      ea = AW'((m_start + m_off) % M);
      ed = (!ce_n && !oe_n) ? m_word : '0;
      compared++;
      if (rd_addr !== ea || dq !== ed || end_n !== m_end) begin
        mismatched++;
        $display("FAIL %s: rd_addr=%h dq=%h end_n=%b expected rd_addr=%h dq=%h end_n=%b",
                 tag, rd_addr, dq, end_n, ea, ed, m_end);
      end
    end
  end

  task automatic drive(input logic ld, input logic adv, input logic [AW-1:0] a);
    @(negedge clk);
    load_n = ld; advance_n = adv; addr = a;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: load and full burst with continuous advance; R3, R5, R6 wrap
    tag = "R1";
    drive(1'b0, 1'b1, 19'h00100);
    tag = "R3_R5_R6";
    for (int i = 0; i < 70; i++) drive(1'b1, 1'b0, 19'h00100);
    // R2, R4: strobes high, address wiggles
    tag = "R2_R4";
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1, AW'(i * 12345));
    // R7: both strobes low
    tag = "R7";
    drive(1'b0, 1'b0, 19'h3A5C0);
    drive(1'b1, 1'b1, 19'h3A5C0);
    drive(1'b1, 1'b1, 19'h3A5C0);
    // R8: start near the top of the address space
    tag = "R8";
    drive(1'b0, 1'b1, 19'h7FFF0);
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, '0);
    // R10: enables combinations
    tag = "R10";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ce_n = i[0]; oe_n = i[1];
      #0.5;
      compared++;
      if (dq !== ((!ce_n && !oe_n) ? m_word : '0)) begin
        mismatched++;
        $display("FAIL R10: dq=%h expected %h", dq, (!ce_n && !oe_n) ? m_word : '0);
      end
    end
    ce_n = 1'b0; oe_n = 1'b0;
    // mixed pseudo-random strobes with reloads in the middle of bursts
    tag = "R1_R3_R4_R7";
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[3:0] != 4'd0, lfsr[5], {lfsr[2:0], lfsr});
    end
    // R9: reset mid-burst
    tag = "R9";
    @(negedge clk); rst = 1'b1; load_n = 1'b1; advance_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule